// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block turns one ALU result into the six arithmetic status flags: carry, parity, auxiliary carry, zero, sign and overflow. It sits beside the ALU datapath. Each cycle it takes the two operands, the result the ALU produced from them, a two-bit operation class, a two-bit operand-size select and an update enable. The new flags word is stored in a register at the next rising clock edge.

Add and subtract results set every flag. Logic results set parity, zero and sign, and force carry, overflow and auxiliary carry low. Operations that only move data leave the stored word as it is, and so does a cycle with the update enable low. Sign, zero, carry and overflow are taken at the selected width of 8, 16 or 32 bits. Parity always looks at the lowest result byte, and auxiliary carry always looks at the nibble boundary between bit 3 and bit 4.

Top module: `stflag_gen`

## Requirements
- R1: While `rst_n` is low, `flags_q` is 0 at each rising edge. The flag word layout is: bit 0 carry, bit 1 parity, bit 2 auxiliary carry, bit 3 zero, bit 4 sign, bit 5 overflow.
- R2: For add (`op_class`=0), carry is the carry out of the most significant bit at the active width. For subtract (`op_class`=1), carry is 1 when the unsigned operand B at that width is larger than the unsigned operand A, which is the borrow.
- R3: Parity is 1 when `res[7:0]` holds an even number of one bits, including none, and 0 when the count is odd. This holds at every operand size.
- R4: For add, auxiliary carry is the carry from bit 3 into bit 4. For subtract, it is the borrow from bit 4 into bit 3, which is 1 when `opb[3:0]` > `opa[3:0]`.
- R5: Zero is 1 exactly when the result bits inside the active width are all 0.
- R6: Sign equals the most significant result bit at the active width.
- R7: For add and subtract, overflow is 1 when the signed result of the operands at the active width falls outside the signed range of that width.
- R8: For a logic operation (`op_class`=2), carry, overflow and auxiliary carry become 0. Parity, zero and sign follow R3, R5 and R6.
- R9: When `op_class`=3 (data move), or when `upd_en` is 0, `flags_q` keeps its previous value.
- R10: `size_sel` picks the width: 0 selects 8 bits, 1 selects 16 bits, 2 and 3 select 32 bits. Operand and result bits above the active width do not affect carry, zero, sign or overflow.
- R11: A flag update appears on `flags_q` at the first rising edge after the inputs are applied. Before that edge, `flags_q` still shows the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_en | input | 1 | Update enable for this cycle |
| op_class | input | 2 | 0 add, 1 subtract, 2 logic, 3 data move |
| size_sel | input | 2 | 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B (subtrahend for subtract) |
| res | input | 32 | ALU result for this operation |
| flags_q | output | 6 | Registered flags word, layout as in R1 |

## Verification
The bench goes after results that wrap to zero at one width while the upper bits are nonzero. A design that takes zero or carry at the wrong width would report a nonzero result or lose the carry. Half-carry and half-borrow cases around bit 3 catch an auxiliary flag taken from the wrong bit or given the wrong polarity for subtract. Signed boundary cases catch an overflow rule applied to the wrong sign combination: 0x7F+1, 0x8000-1, and a subtract whose operands have opposite signs.

Several further cases each catch a specific fault:
- A result whose low byte has even parity but whose full word has odd parity catches parity computed over the whole word.
- A logic operation that follows a carry-setting add catches carry or overflow left standing.
- Move operations and cycles with the enable low catch a register that updates when it must hold.
- An early sample before the clock edge catches a flag path that is not registered.

// File: rtl/stflag_pkg.sv
package stflag_pkg;
   localparam int FLG_W = 6;
   localparam int FLG_C = 0;
   localparam int FLG_P = 1;
   localparam int FLG_A = 2;
   localparam int FLG_Z = 3;
   localparam int FLG_S = 4;
   localparam int FLG_O = 5;

   typedef enum logic [1:0] {
      OPC_ADD   = 2'd0,
      OPC_SUB   = 2'd1,
      OPC_LOGIC = 2'd2,
      OPC_MOVE  = 2'd3
   } opc_e;

   typedef struct packed {
      logic ovf;
      logic sgn;
      logic zro;
      logic aux;
      logic par;
      logic cry;
   } flags_t;
endpackage

// File: rtl/stflag_slice.sv
module stflag_slice #(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        size_sel,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] res,
   output logic              a_top,
   output logic              b_top,
   output logic              r_top,
   output logic              r_zero
);
   localparam int LANES = 3;

   logic [LANES-1:0] at;
   logic [LANES-1:0] bt;
   logic [LANES-1:0] rt;
   logic [LANES-1:0] rz;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int LW = DATA_W >> (LANES - 1 - k);
      assign at[k] = opa[LW-1];
      assign bt[k] = opb[LW-1];
      assign rt[k] = res[LW-1];
      assign rz[k] = (res[LW-1:0] == '0);
   end

   always_comb begin
      case (size_sel)
         2'd0: begin
            a_top = at[0]; b_top = bt[0]; r_top = rt[0]; r_zero = rz[0];
         end
         2'd1: begin
            a_top = at[1]; b_top = bt[1]; r_top = rt[1]; r_zero = rz[1];
         end
         default: begin
            a_top = at[2]; b_top = bt[2]; r_top = rt[2]; r_zero = rz[2];
         end
      endcase
   end
endmodule

// File: rtl/stflag_arith.sv
module stflag_arith
   import stflag_pkg::*;
(
   input  opc_e op,
   input  logic a_top,
   input  logic b_top,
   input  logic r_top,
   input  logic a_nib,
   input  logic b_nib,
   input  logic r_nib,
   output logic cry,
   output logic aux,
   output logic ovf
);
   logic add_cry;
   logic sub_brw;
   logic nib_x;

   assign add_cry = (a_top & b_top) | ((a_top | b_top) & ~r_top);
   assign sub_brw = (~a_top & b_top) | ((~a_top | b_top) & r_top);
   assign nib_x   = a_nib ^ b_nib ^ r_nib;

   always_comb begin
      cry = 1'b0;
      aux = 1'b0;
      ovf = 1'b0;
      case (op)
         OPC_ADD: begin
            cry = add_cry;
            aux = nib_x;
            ovf = (a_top == b_top) && (r_top != a_top);
         end
         OPC_SUB: begin
            cry = sub_brw;
            aux = nib_x;
            ovf = (a_top != b_top) && (r_top != a_top);
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/stflag_parity.sv
module stflag_parity #(
   parameter int PAR_W = 8
) (
   input  logic [PAR_W-1:0] bits,
   output logic             even
);
   assign even = ~(^bits);
endmodule

// File: rtl/stflag_gen.sv
module stflag_gen
   import stflag_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int PAR_W   = 8,
   parameter int NIB_POS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [1:0]        op_class,
   input  logic [1:0]        size_sel,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] res,
   output logic [FLG_W-1:0]  flags_q
);
   localparam int NARROW_W = DATA_W / 4;

   if ((DATA_W % 4) != 0 || NARROW_W < 8) begin : g_bad_width
      $error("stflag_gen: DATA_W must be a multiple of 4 with a narrow lane of at least 8");
   end
   if (PAR_W < 1 || PAR_W > NARROW_W) begin : g_bad_par
      $error("stflag_gen: PAR_W must fit in the narrow lane");
   end
   if (NIB_POS < 1 || NIB_POS >= NARROW_W) begin : g_bad_nib
      $error("stflag_gen: NIB_POS must lie inside the narrow lane");
   end

   opc_e   op;
   logic   a_top, b_top, r_top, r_zero;
   logic   cry, aux, ovf, par;
   flags_t nxt;
   flags_t cur;
   logic   take;

   assign op = opc_e'(op_class);

   stflag_slice #(.DATA_W(DATA_W)) u_slice (
      .size_sel (size_sel),
      .opa      (opa),
      .opb      (opb),
      .res      (res),
      .a_top    (a_top),
      .b_top    (b_top),
      .r_top    (r_top),
      .r_zero   (r_zero)
   );

   stflag_arith u_arith (
      .op    (op),
      .a_top (a_top),
      .b_top (b_top),
      .r_top (r_top),
      .a_nib (opa[NIB_POS]),
      .b_nib (opb[NIB_POS]),
      .r_nib (res[NIB_POS]),
      .cry   (cry),
      .aux   (aux),
      .ovf   (ovf)
   );

   stflag_parity #(.PAR_W(PAR_W)) u_par (
      .bits (res[PAR_W-1:0]),
      .even (par)
   );

   always_comb begin
      nxt.cry = cry;
      nxt.par = par;
      nxt.aux = aux;
      nxt.zro = r_zero;
      nxt.sgn = r_top;
      nxt.ovf = ovf;
   end

   assign take = upd_en && (op != OPC_MOVE);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cur <= '0;
      else if (take)
         cur <= nxt;
   end

   assign flags_q = cur;
endmodule

// File: rtl/stflag_chk.sv
module stflag_chk
   import stflag_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_en,
   input logic [1:0]        op_class,
   input logic [1:0]        size_sel,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic [DATA_W-1:0] res,
   input logic [FLG_W-1:0]  flags_q
);
   logic active;
   assign active = upd_en && (op_class != 2'd3);

   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> flags_q == '0); // R1

   AST_HOLD_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && op_class == 2'd3) |=> $stable(flags_q)); // R9

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(flags_q)); // R9

   AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && op_class == 2'd2) |=>
      (!flags_q[FLG_C] && !flags_q[FLG_O] && !flags_q[FLG_A])); // R8

   AST_PARITY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> flags_q[FLG_P] == ($countones($past(res[7:0])) % 2 == 0)); // R3

   AST_SIGN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (active && size_sel == 2'd0) |=> flags_q[FLG_S] == $past(res[7])); // R6

   AST_ZERO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (active && size_sel[1]) |=> flags_q[FLG_Z] == ($past(res) == '0)); // R5

   AST_ADD_CARRY_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && op_class == 2'd0 && size_sel == 2'd0) |=>
      flags_q[FLG_C] == ($past({1'b0, opa[7:0]} + {1'b0, opb[7:0]}) >> 8)); // R2
endmodule

bind stflag_gen stflag_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/stflag_gen_tb.sv
module stflag_gen_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_en = 1'b0;
   logic [1:0]  op_class = 2'd3;
   logic [1:0]  size_sel = 2'd0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic [31:0] res = '0;
   logic [5:0]  flags_q;

   int n_run  = 0;
   int n_fail = 0;
   logic [5:0] exp_q = '0;
   logic done = 1'b0;

   stflag_gen dut_i (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
      .size_sel(size_sel), .opa(opa), .opb(opb), .res(res), .flags_q(flags_q)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int width_of(logic [1:0] s);
      return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
   endfunction

   function automatic longint sx(logic [31:0] v, int w);
      longint t;
      t = longint'(v) & ((64'sd1 <<< w) - 1);
      if (((t >>> (w - 1)) & 1) != 0) t = t - (64'sd1 <<< w);
      return t;
   endfunction

   task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: flags actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // one clocked step: drive at negedge, model the update, compare after the edge
   task automatic step(logic [1:0] op, logic [1:0] sz, logic [31:0] a, logic [31:0] b,
                       logic [31:0] lres, logic en, string tag, bit early = 0);
      int w;
      longint mask, ua, ub, s, smax, smin;
      logic [31:0] r;
      logic c, ax, ov;
      logic [5:0] nx;
      @(negedge clk);
      w = width_of(sz);
      mask = (64'sd1 <<< w) - 1;
      ua = longint'(a) & mask;
      ub = longint'(b) & mask;
      smax = (64'sd1 <<< (w - 1)) - 1;
      smin = -(64'sd1 <<< (w - 1));
      c = 0; ax = 0; ov = 0; s = 0;
      case (op)
         2'd0: begin
            r = a + b;
            c = (((ua + ub) >>> w) & 1) != 0;
            ax = ((a & 32'hF) + (b & 32'hF)) > 32'hF;
            s = sx(a, w) + sx(b, w);
            ov = (s > smax) || (s < smin);
         end
         2'd1: begin
            r = a - b;
            c = ua < ub;
            ax = (a & 32'hF) < (b & 32'hF);
            s = sx(a, w) - sx(b, w);
            ov = (s > smax) || (s < smin);
         end
         default: r = lres;
      endcase
      nx[0] = c;
      nx[1] = ($countones(r[7:0]) % 2) == 0;
      nx[2] = ax;
      nx[3] = (longint'(r) & mask) == 0;
      nx[4] = ((longint'(r) >>> (w - 1)) & 1) != 0;
      nx[5] = ov;
      op_class = op; size_sel = sz; opa = a; opb = b; res = r; upd_en = en;
      if (early) begin
         #(CLK_PERIOD/4);
         check({tag, " R11 before edge"}, flags_q, exp_q);
      end
      if (en && op != 2'd3) exp_q = nx;
      @(posedge clk);
      #1;
      check(tag, flags_q, exp_q);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset state", flags_q, 6'b0);
      @(negedge clk);
      rst_n = 1'b1;

      step(2'd0, 2'd0, 32'hFF, 32'h01, 0, 1, "R2 R5 add byte carry and zero");
      step(2'd0, 2'd0, 32'h7F, 32'h01, 0, 1, "R7 R6 add byte overflow and sign", 1);
      step(2'd1, 2'd0, 32'h00, 32'h01, 0, 1, "R2 R4 sub byte borrow");
      step(2'd1, 2'd1, 32'h8000, 32'h0001, 0, 1, "R7 sub word overflow");
      step(2'd1, 2'd0, 32'h80, 32'h01, 0, 1, "R7 sub byte opposite signs");
      step(2'd0, 2'd2, 32'hFFFF_FFFF, 32'h1, 0, 1, "R2 R5 add dword wrap");
      step(2'd0, 2'd0, 32'h0001_0000, 32'h0, 0, 1, "R10 R5 upper bits ignored at byte");
      step(2'd0, 2'd1, 32'hABCD_8000, 32'h1234_8000, 0, 1, "R10 R2 word carry upper ignored");
      step(2'd0, 2'd3, 32'h7FFF_FFFF, 32'h1, 0, 1, "R10 size 3 as dword");
      step(2'd0, 2'd2, 32'h0100_0001, 32'h2, 0, 1, "R3 parity low byte only");
      step(2'd0, 2'd0, 32'h08, 32'h08, 0, 1, "R4 add half carry");
      step(2'd1, 2'd0, 32'h10, 32'h01, 0, 1, "R4 sub half borrow");
      step(2'd0, 2'd0, 32'hFF, 32'hFF, 0, 1, "R2 set carry before logic");
      step(2'd2, 2'd0, 32'hF0, 32'h0F, 32'h0, 1, "R8 logic clears carry aux overflow");
      step(2'd0, 2'd0, 32'h7F, 32'h7F, 0, 1, "R7 set overflow before hold");
      step(2'd3, 2'd0, 32'h0, 32'h0, 32'h0, 1, "R9 move holds flags");
      step(2'd2, 2'd0, 32'h0, 32'h0, 32'h0, 0, "R9 enable low holds flags");
      step(2'd2, 2'd1, 32'hFFFF, 32'h8000, 32'h8000, 1, "R8 R6 logic word sign");

      lf = 32'h1ACE_B00C;
      for (int i = 0; i < 400; i++) begin
         lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
         begin
            logic [31:0] a2, b2;
            a2 = lf;
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            b2 = (lf[3]) ? {24'h0, lf[31:24]} : lf;
            step(lf[1:0], lf[5:4], a2, b2, a2 ^ b2, lf[9] | lf[10], "random R2 R7");
         end
      end

      @(negedge clk);
      rst_n = 1'b0;
      exp_q = '0;
      @(posedge clk);
      #1;
      check("R1 reset clears live flags", flags_q, 6'b0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule